// File: doc/BRIEF.md
# Dual Q15 Fractional Multiplier

This block is the two-lane signed 16x16 multiply datapath of a 32-bit media extension. Each source word carries two signed 16-bit halves. A 2-bit pairing option picks which halves meet in each of the two multipliers, so one issue yields two 32-bit products, called lane A and lane D. A decoded function code and a 2-bit sub-operation pick one of three modes. The integer mode returns the raw products. The split fractional mode returns both products in Q15 scaling with optional rounding. The packed fractional mode rounds both products and merges their upper halves into one word.

Two bits of the control register govern rounding in the fractional modes. Bit 1 turns rounding on. Bit 2 picks biased rounding (always add half) or round-half-to-even, and it matters only in the packed mode. Results are registered, so they appear one clock after the issue cycle, together with per-destination write enables and a reserved-operation flag. The register file and any accumulation sit outside the block.

Top module: `q15_dual_mul`

## Requirements
- R1: While rst_n is low, and at the first sample after it is released, dst_a, dst_d, we_a, we_d and illegal are all zero.
- R2: Outputs show the result of the issue made on the previous clock. A cycle without valid_in, or with a function code other than 0x08 or 0x09, gives zero on all five outputs at the next clock. dst_a and dst_d read zero whenever their write enable is low.
- R3: Function code 0x09 with sub_op 2 or 3 sets illegal and leaves both write enables low. Sub_op 0 selects the packed fractional mode and sub_op 1 the split fractional mode. Function code 0x08 selects the integer mode.
- R4: Halves are lo = bits 15:0 and hi = bits 31:16, both signed. Lane A multiplies a src_b half by src_c hi; lane D multiplies a src_b half by src_c lo. pair_opt 0 gives A=hi·hi and D=lo·lo. pair_opt 1 gives A=lo·hi and D=lo·lo. pair_opt 2 gives A=hi·hi and D=hi·lo. pair_opt 3 gives A=lo·hi and D=hi·lo. In each product the src_b half is written first.
- R5: In the integer mode both 32-bit signed products go out unchanged on dst_a and dst_d, with both write enables set, whatever ctrl_reg holds.
- R6: In both fractional modes each product is shifted left by one bit. When ctrl_reg bit 1 is clear, the shifted values are used as they are.
- R7: In the split fractional mode with ctrl_reg bit 1 set, 0x8000 is added to each shifted product. The two 32-bit sums go to dst_a and dst_d with both write enables set.
- R8: In the packed mode, with ctrl_reg bit 1 set and bit 2 set, 0x8000 is added to each shifted product with no condition.
- R9: In the packed mode, with ctrl_reg bit 1 set and bit 2 clear, 0x8000 is added to a shifted product unless its low 17 bits equal exactly 0x08000. Exact halves therefore round toward an even kept half.
- R10: The packed mode writes only dst_a. Its bits 31:16 are bits 31:16 of the lane A result and its bits 15:0 are bits 31:16 of the lane D result. we_d stays low.
- R11: There is no saturation. 0x8000 times 0x8000, doubled, wraps to 0x80000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Issue strobe for this cycle |
| func_code | input | 6 | Major function code (0x08 integer, 0x09 fractional group) |
| sub_op | input | 2 | Sub-operation within the fractional group |
| pair_opt | input | 2 | Operand-pairing option |
| src_b | input | 32 | First source word, two signed halves |
| src_c | input | 32 | Second source word, two signed halves |
| ctrl_reg | input | 32 | Control register; bit 1 round enable, bit 2 biased rounding |
| dst_a | output | 32 | Lane A result, or the packed word |
| dst_d | output | 32 | Lane D result |
| we_a | output | 1 | Write enable for dst_a |
| we_d | output | 1 | Write enable for dst_d |
| illegal | output | 1 | Reserved sub-operation flag |

## Verification
Rounding and packing fall in the same cycle in the packed mode. The two lanes each decide round-half-to-even for themselves, and then both feed one merged word. The bench provokes this with operand pairs that put an exact half with an even kept bit in one lane and an odd kept bit in the other. It also uses random issues with the bias bit toggled. A behavioural model computes each lane with plain integer arithmetic, masks it and merges the halves, and the bench judges each packed word half by half against that model one clock after issue.

// File: rtl/q15_pkg.sv
package q15_pkg;
  localparam int HALF_W   = 16;
  localparam int FUNC_W   = 6;
  localparam logic [FUNC_W-1:0] FN_INT  = 6'h08;
  localparam logic [FUNC_W-1:0] FN_FRAC = 6'h09;
  localparam int RND_EN_BIT = 1;
  localparam int BIAS_BIT   = 2;

  typedef enum logic [1:0] {
    MD_NONE = 2'd0,
    MD_INT  = 2'd1,
    MD_SEP  = 2'd2,
    MD_PACK = 2'd3
  } mode_e;
endpackage

// File: rtl/q15_decode.sv
module q15_decode
  import q15_pkg::*;
(
  input  logic              valid_in,
  input  logic [FUNC_W-1:0] func_code,
  input  logic [1:0]        sub_op,
  output mode_e             mode,
  output logic              illegal
);
  always_comb begin
    mode    = MD_NONE;
    illegal = 1'b0;
    if (valid_in) begin
      if (func_code == FN_INT) begin
        mode = MD_INT;
      end else if (func_code == FN_FRAC) begin
        case (sub_op)
          2'd0:    mode = MD_PACK;
          2'd1:    mode = MD_SEP;
          default: illegal = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/q15_operand_sel.sv
module q15_operand_sel #(
  parameter int HW = 16
) (
  input  logic [2*HW-1:0]     src_b,
  input  logic [2*HW-1:0]     src_c,
  input  logic [1:0]          pair_opt,
  output logic signed [HW-1:0] a_x,
  output logic signed [HW-1:0] a_y,
  output logic signed [HW-1:0] d_x,
  output logic signed [HW-1:0] d_y
);
  logic [HW-1:0] b_lo, b_hi;
  assign b_lo = src_b[HW-1:0];
  assign b_hi = src_b[2*HW-1:HW];

  always_comb begin
    a_x = pair_opt[0] ? b_lo : b_hi;
    d_x = pair_opt[1] ? b_hi : b_lo;
    a_y = src_c[2*HW-1:HW];
    d_y = src_c[HW-1:0];
  end
endmodule

// File: rtl/q15_round_lane.sv
module q15_round_lane #(
  parameter int HW = 16
) (
  input  logic [2*HW-1:0] prod,
  input  logic            frac,
  input  logic            round_en,
  input  logic            unbiased,
  output logic [2*HW-1:0] result,
  output logic            tie_hit
);
  localparam int PW = 2 * HW;
  localparam logic [PW-1:0] HALF = PW'(1) << (HW - 1);

  function automatic logic [PW-1:0] dbl(input logic [PW-1:0] p);
    return p << 1;
  endfunction

  function automatic logic is_even_tie(input logic [PW-1:0] s);
    return s[HW:0] == HALF[HW:0];
  endfunction

  logic [PW-1:0] shifted;
  logic          add_half;

  assign shifted  = dbl(prod);
  assign tie_hit  = is_even_tie(shifted);
  assign add_half = round_en && !(unbiased && tie_hit);
  assign result   = !frac ? prod : (add_half ? shifted + HALF : shifted);
endmodule

// File: rtl/q15_dual_mul.sv
module q15_dual_mul
  import q15_pkg::*;
#(
  parameter int HW = q15_pkg::HALF_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid_in,
  input  logic [FUNC_W-1:0]   func_code,
  input  logic [1:0]          sub_op,
  input  logic [1:0]          pair_opt,
  input  logic [2*HW-1:0]     src_b,
  input  logic [2*HW-1:0]     src_c,
  input  logic [2*HW-1:0]     ctrl_reg,
  output logic [2*HW-1:0]     dst_a,
  output logic [2*HW-1:0]     dst_d,
  output logic                we_a,
  output logic                we_d,
  output logic                illegal
);
  localparam int PW = 2 * HW;
  localparam int NL = 2;

  mode_e mode;
  logic  illegal_c;

  q15_decode u_dec (
    .valid_in (valid_in),
    .func_code(func_code),
    .sub_op   (sub_op),
    .mode     (mode),
    .illegal  (illegal_c)
  );

  logic signed [HW-1:0] ax, ay, dx, dy;

  q15_operand_sel #(.HW(HW)) u_sel (
    .src_b   (src_b),
    .src_c   (src_c),
    .pair_opt(pair_opt),
    .a_x     (ax),
    .a_y     (ay),
    .d_x     (dx),
    .d_y     (dy)
  );

  logic signed [PW-1:0] prod [NL];
  assign prod[0] = ax * ay;
  assign prod[1] = dx * dy;

  logic frac_mode, rnd_on, unbiased;
  assign frac_mode = (mode == MD_SEP) || (mode == MD_PACK);
  assign rnd_on    = ctrl_reg[RND_EN_BIT];
  assign unbiased  = (mode == MD_PACK) && !ctrl_reg[BIAS_BIT];

  logic [PW-1:0] lane_res [NL];
  logic [NL-1:0] lane_tie;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    q15_round_lane #(.HW(HW)) u_rnd (
      .prod    (prod[g]),
      .frac    (frac_mode),
      .round_en(rnd_on),
      .unbiased(unbiased),
      .result  (lane_res[g]),
      .tie_hit (lane_tie[g])
    );
  end

  logic          wa_c, wd_c;
  logic [PW-1:0] a_c, d_c;

  always_comb begin
    wa_c = (mode != MD_NONE);
    wd_c = (mode == MD_INT) || (mode == MD_SEP);
    a_c  = '0;
    d_c  = '0;
    if (mode == MD_PACK)
      a_c = {lane_res[0][PW-1:HW], lane_res[1][PW-1:HW]};
    else if (wa_c)
      a_c = lane_res[0];
    if (wd_c)
      d_c = lane_res[1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst_a   <= '0;
      dst_d   <= '0;
      we_a    <= 1'b0;
      we_d    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      dst_a   <= a_c;
      dst_d   <= d_c;
      we_a    <= wa_c;
      we_d    <= wd_c;
      illegal <= illegal_c;
    end
  end
endmodule

// File: rtl/q15_dual_mul_chk.sv
module q15_dual_mul_chk
  import q15_pkg::*;
#(
  parameter int HW = q15_pkg::HALF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid_in,
  input logic [FUNC_W-1:0] func_code,
  input logic [1:0]        sub_op,
  input logic [2*HW-1:0]   dst_a,
  input logic [2*HW-1:0]   dst_d,
  input logic              we_a,
  input logic              we_d,
  input logic              illegal
);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> (!we_a && !we_d && !illegal));

  // R3
  illegal_noWrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!we_a && !we_d));

  // R3
  reserved_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && func_code == FN_FRAC && sub_op[1]) |=> illegal);

  // R5
  int_both_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && func_code == FN_INT) |=> (we_a && we_d));

  // R10
  packed_single_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && func_code == FN_FRAC && sub_op == 2'd0) |=> (we_a && !we_d));

  // R2
  d_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_d |-> (dst_d == '0));

  // R2
  a_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_a |-> (dst_a == '0));
endmodule

bind q15_dual_mul q15_dual_mul_chk #(.HW(HW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .valid_in (valid_in),
  .func_code(func_code),
  .sub_op   (sub_op),
  .dst_a    (dst_a),
  .dst_d    (dst_d),
  .we_a     (we_a),
  .we_d     (we_d),
  .illegal  (illegal)
);

// File: tb/q15_dual_mul_bench.sv
module q15_dual_mul_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [5:0]  func_code = '0;
  logic [1:0]  sub_op = '0;
  logic [1:0]  pair_opt = '0;
  logic [31:0] src_b = '0, src_c = '0, ctrl_reg = '0;
  logic [31:0] dst_a, dst_d;
  logic        we_a, we_d, illegal;

  always #2.5 clk = ~clk;

  q15_dual_mul u_q15_dual_mul (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .func_code(func_code),
    .sub_op(sub_op), .pair_opt(pair_opt), .src_b(src_b), .src_c(src_c),
    .ctrl_reg(ctrl_reg), .dst_a(dst_a), .dst_d(dst_d), .we_a(we_a),
    .we_d(we_d), .illegal(illegal)
  );

  typedef struct {
    logic [31:0] a, d;
    logic        wa, wd, il;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0, n_bad = 0;
  bit   finished = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic longint sx16(logic [15:0] h);
    return longint'($signed(h));
  endfunction

  function automatic longint frac_lane(longint p, bit rnd, bit unb);
    longint s;
    s = (p * 2) & 64'hFFFF_FFFF;
    if (rnd && !(unb && ((s & 64'h1FFFF) == 64'h08000)))
      s = s + 64'h8000;
    return s & 64'hFFFF_FFFF;
  endfunction

  function automatic exp_t model(bit v, logic [5:0] fc, logic [1:0] so, logic [1:0] po,
                                 logic [31:0] b, logic [31:0] c, logic [31:0] cr);
    exp_t e;
    longint pa, pd, ra, rd, bx, bl;
    e.a = 0; e.d = 0; e.wa = 0; e.wd = 0; e.il = 0; e.tag = "R2";
    // R4 pairing: first factor from src_b (hi when opt bit0 clear for A,
    // hi when opt bit1 set for D); second from src_c hi (A) / lo (D)
    bx = (po == 2'd1 || po == 2'd3) ? sx16(b[15:0]) : sx16(b[31:16]);
    bl = (po >= 2'd2) ? sx16(b[31:16]) : sx16(b[15:0]);
    pa = bx * sx16(c[31:16]);
    pd = bl * sx16(c[15:0]);
    if (!v) return e;
    if (fc == 6'h08) begin
      e.a = 32'(pa); e.d = 32'(pd); e.wa = 1; e.wd = 1; e.tag = "R5";
    end else if (fc == 6'h09) begin
      if (so >= 2'd2) begin
        e.il = 1; e.tag = "R3";
      end else if (so == 2'd1) begin
        ra = frac_lane(pa, cr[1], 0); rd = frac_lane(pd, cr[1], 0);
        e.a = 32'(ra); e.d = 32'(rd); e.wa = 1; e.wd = 1;
        e.tag = cr[1] ? "R7" : "R6";
      end else begin
        ra = frac_lane(pa, cr[1], !cr[2]); rd = frac_lane(pd, cr[1], !cr[2]);
        e.a = {ra[31:16], rd[31:16]}; e.wa = 1;
        e.tag = !cr[1] ? "R10" : (cr[2] ? "R8" : "R9");
      end
    end
    return e;
  endfunction

  // compare previous issue, then drive the next one (all at negedge)
  task automatic issue(bit v, logic [5:0] fc, logic [1:0] so, logic [1:0] po,
                       logic [31:0] b, logic [31:0] c, logic [31:0] cr, string tag_ovr);
    exp_t e, p;
    @(negedge clk);
    if (exp_q.size() > 0) begin
      p = exp_q.pop_front();
      chk(p.tag, "dst_a", dst_a, p.a);
      chk(p.tag, "dst_d", dst_d, p.d);
      chk(p.tag, "we_a", 32'(we_a), 32'(p.wa));
      chk(p.tag, "we_d", 32'(we_d), 32'(p.wd));
      chk(p.tag, "illegal", 32'(illegal), 32'(p.il));
    end
    valid_in = v; func_code = fc; sub_op = so; pair_opt = po;
    src_b = b; src_c = c; ctrl_reg = cr;
    e = model(v, fc, so, po, b, c, cr);
    if (tag_ovr != "") e.tag = tag_ovr;
    exp_q.push_back(e);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs during reset
    chk("R1", "dst_a", dst_a, 0); chk("R1", "dst_d", dst_d, 0);
    chk("R1", "flags", {29'd0, we_a, we_d, illegal}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 first sample after release
    chk("R1", "flags_after", {29'd0, we_a, we_d, illegal}, 0);

    // R2 idle issues and foreign function codes
    issue(0, 6'h09, 0, 0, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 32'h6, "R2");
    issue(1, 6'h0A, 0, 0, 32'h1234_5678, 32'h1111_2222, 32'h6, "R2");
    // R4 every pairing, integer mode with distinct halves
    for (int po = 0; po < 4; po++)
      issue(1, 6'h08, 0, 2'(po), 32'h0003_0005, 32'h0007_000B, 32'h0, "R4");
    for (int po = 0; po < 4; po++)
      issue(1, 6'h09, 1, 2'(po), 32'hFFFD_0005, 32'h0007_FFF5, 32'h2, "R4");
    // R5 integer ignores control bits
    issue(1, 6'h08, 0, 0, 32'h8000_7FFF, 32'h8000_7FFF, 32'h6, "R5");
    // R6 fractional without rounding
    issue(1, 6'h09, 1, 0, 32'h4000_C000, 32'h4000_4000, 32'h0, "R6");
    // R7 split rounding
    issue(1, 6'h09, 1, 0, 32'h0080_00C0, 32'h0080_0100, 32'h2, "R7");
    // R9 exact halves: A even kept bit (0x80*0x80), D odd (0xC0*0x100)
    issue(1, 6'h09, 0, 0, 32'h0080_00C0, 32'h0080_0100, 32'h2, "R9");
    // R8 same operands, biased
    issue(1, 6'h09, 0, 0, 32'h0080_00C0, 32'h0080_0100, 32'h6, "R8");
    // R10 packing with rounding off
    issue(1, 6'h09, 0, 0, 32'h1234_FEDC, 32'h4321_0123, 32'h0, "R10");
    // R3 reserved sub-ops
    issue(1, 6'h09, 2, 0, 32'h1, 32'h1, 32'h2, "R3");
    issue(1, 6'h09, 3, 1, 32'h1, 32'h1, 32'h2, "R3");
    // R11 full-scale negative wraps in every mode
    issue(1, 6'h09, 1, 0, 32'h8000_8000, 32'h8000_8000, 32'h0, "R11");
    issue(1, 6'h09, 1, 0, 32'h8000_8000, 32'h8000_8000, 32'h2, "R11");
    issue(1, 6'h09, 0, 0, 32'h8000_8000, 32'h8000_8000, 32'h2, "R11");
    // random back-to-back issues
    for (int i = 0; i < 600; i++)
      issue(($urandom % 8) != 0, ($urandom % 2) ? 6'h09 : 6'h08, 2'($urandom),
            2'($urandom), $urandom, $urandom, 32'($urandom % 8), "");
    issue(0, 0, 0, 0, 0, 0, 0, "R2");
    issue(0, 0, 0, 0, 0, 0, 0, "R2");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule